// File: doc/BRIEF.md
# Serial-Memory-Style I2C Register Target

This block is an I2C target that gives a host access to a 16-bit register space the way a serial memory device does. After a START the host sends a 7-bit device address. The target recognises a group of eight consecutive addresses, and it treats the three least significant address bits as don't-care. In a write transaction the host first sends a two-byte register pointer and then any number of data bytes. Each data byte is written to the location the pointer holds, and the pointer then moves on by one.

A read begins with a pointer write. The host then issues a repeated START with the read bit set, and the target returns bytes starting at the stored pointer. The pointer advances after every byte, whether the byte was read or written. It keeps its value from one transaction to the next, so a later read transaction with no pointer bytes continues where the last access stopped.

On the inside, the target drives a simple register bus. The bus has a pointer output, a one-cycle write strobe carrying the data byte, and a one-cycle read strobe. The register space returns its byte on the cycle after the read strobe. On the bus side, SDA is only ever pulled low or released.

Top module: `i2c_regbank_target`

## Requirements
- R1: A device byte whose upper four address bits are 0b0101 (7-bit addresses 0x28 to 0x2F) is acknowledged. Any other address gets no ACK, and the target ignores the bus until the next START, with no strobe and no SDA drive.
- R2: In a write transaction, the two bytes after the device byte form the register pointer, more significant byte first. The first data byte is written at that pointer.
- R3: Each data byte in a write stream raises `reg_we` for one cycle, with `reg_addr` at the current pointer. The pointer then advances by one and wraps from 0xFFFF to 0x0000.
- R4: After a device byte with the read bit (bit 0 = 1), the target raises `reg_re` for one cycle at the pointer. It samples `reg_rdata` on the following cycle and shifts that byte out MSB first, starting at the falling SCL edge that ends the address ACK.
- R5: Each byte sent in a read advances the pointer by one. A master ACK (SDA low on the ninth clock) causes the next byte to be fetched. A master NACK ends the transfer with SDA released and no further fetch.
- R6: The pointer persists across transactions. A read transaction that sends no pointer bytes starts at the pointer left by the previous access.
- R7: The target acknowledges every byte written to it: the matching device byte, both pointer bytes and every data byte.
- R8: A STOP, or a START in the middle of a byte, abandons the byte in progress. No write happens, the pointer keeps its value, and after a START the target decodes a new device byte.
- R9: After reset, SDA is released, both strobes are low and the pointer is 0x0000.
- R10: `reg_we` and `reg_re` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 16 | Register pointer |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_wdata | output | 8 | Data byte for a write |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_re` |

## Verification
Two things happen in the same clock cycle in this block. A byte is committed to the register bus, as a write strobe or a read fetch, and the pointer is stepped. The strobe must carry the pointer value from before the step. The bench provokes this with write and read streams that cross the 0xFFFF to 0x0000 wrap. It judges the result from the logged addresses of the write strobes and from the bytes read back in the same order. A persistent-pointer read and a START that interrupts a byte then confirm that the pointer landed on the expected value.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        BK_DEV,
        BK_PTR,
        BK_DATA
    } byte_kind_e;

    // Bus events seen on the synchronised lines.
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic cond_start;
        logic cond_stop;
        logic sda;
    } bus_ev_t;

    // Mask of the device-address bits that take part in the match.
    function automatic logic [6:0] dev_mask(input int keep_bits);
        return 7'h7F << (7 - keep_bits);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    // chain[g] = {scl, sda} after g+1 flops
    logic [1:0] chain [DEPTH];
    logic [1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 2'b11;
        else     chain[0] <= {scl_i, sda_i};
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 2'b11;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b11;
        else     prev <= chain[DEPTH-1];
    end

    logic scl_s, sda_s, scl_p, sda_p;
    assign scl_s = chain[DEPTH-1][1];
    assign sda_s = chain[DEPTH-1][0];
    assign scl_p = prev[1];
    assign sda_p = prev[0];

    always_comb begin
        ev.scl_rise   = scl_s & ~scl_p;
        ev.scl_fall   = ~scl_s & scl_p;
        ev.cond_start = scl_s & scl_p & sda_p & ~sda_s;
        ev.cond_stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev.sda        = sda_s;
    end

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + 1'b1;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter logic [6:0] DEV_BASE  = 7'h28,
    parameter int         DEV_KEEP  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic              we,
    output logic              re,
    output logic [BYTE_W-1:0] wdata,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_val
);

    localparam int         PTR_BYTES = ADDR_W / BYTE_W;
    localparam int         IDX_W     = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;
    localparam logic [6:0] MASK      = dev_mask(DEV_KEEP);

    phase_e            phase;
    byte_kind_e        kind;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] rd_buf;
    logic              rd_pend;
    logic              is_read;
    logic              more;
    logic [IDX_W-1:0]  ptr_idx;

    logic addr_hit;
    assign addr_hit = ((sr[7:1] & MASK) == (DEV_BASE & MASK));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            kind     <= BK_DEV;
            bitcnt   <= '0;
            sr       <= '0;
            rd_buf   <= '0;
            rd_pend  <= 1'b0;
            is_read  <= 1'b0;
            more     <= 1'b0;
            ptr_idx  <= '0;
            ptr_val  <= '0;
            sda_oe   <= 1'b0;
            we       <= 1'b0;
            re       <= 1'b0;
            wdata    <= '0;
            ptr_load <= 1'b0;
        end else begin
            we       <= 1'b0;
            re       <= 1'b0;
            ptr_load <= 1'b0;
            rd_pend  <= re;
            if (rd_pend) rd_buf <= rdata;

            if (ev.cond_stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.cond_start) begin
                phase  <= PH_RX;
                kind   <= BK_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: ;
                    PH_RX: begin
                        if (ev.scl_rise) begin
                            sr     <= {sr[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            unique case (kind)
                                BK_DEV: begin
                                    if (addr_hit) begin
                                        sda_oe  <= 1'b1;
                                        phase   <= PH_ACK;
                                        is_read <= sr[0];
                                        re      <= sr[0];
                                        kind    <= sr[0] ? BK_DATA : BK_PTR;
                                        ptr_idx <= '0;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                BK_PTR: begin
                                    sda_oe  <= 1'b1;
                                    phase   <= PH_ACK;
                                    ptr_val <= {ptr_val[ADDR_W-BYTE_W-1:0], sr};
                                    if (ptr_idx == IDX_W'(PTR_BYTES - 1)) begin
                                        ptr_load <= 1'b1;
                                        kind     <= BK_DATA;
                                    end else begin
                                        ptr_idx <= ptr_idx + 1'b1;
                                    end
                                end
                                default: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_ACK;
                                    we     <= 1'b1;
                                    wdata  <= sr;
                                end
                            endcase
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                phase  <= PH_TX;
                                sda_oe <= ~rd_buf[7];
                                sr     <= {rd_buf[6:0], 1'b0};
                            end else begin
                                phase  <= PH_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_MACK;
                            end else begin
                                sda_oe <= ~sr[7];
                                sr     <= {sr[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    PH_MACK: begin
                        if (ev.scl_rise) begin
                            more <= ~ev.sda;
                            re   <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (more) begin
                                phase  <= PH_TX;
                                sda_oe <= ~rd_buf[7];
                                sr     <= {rd_buf[6:0], 1'b0};
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter logic [6:0] DEV_BASE   = 7'h28,
    parameter int         DEV_KEEP   = 4,
    parameter int         SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic              reg_re,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);

    bus_ev_t           ev;
    logic              ptr_load;
    logic [ADDR_W-1:0] ptr_val;

    i2c_tgt_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_tgt_engine #(
        .ADDR_W   (ADDR_W),
        .DEV_BASE (DEV_BASE),
        .DEV_KEEP (DEV_KEEP)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rdata    (reg_rdata),
        .sda_oe   (sda_oe),
        .we       (reg_we),
        .re       (reg_re),
        .wdata    (reg_wdata),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val)
    );

    // Each committed byte, written or fetched, steps the pointer.
    i2c_tgt_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_val),
        .step     (reg_we | reg_re),
        .ptr      (reg_addr)
    );

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr
);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    p_we_single_r10: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    p_re_single_r4: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    p_we_step_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

    p_re_step_r5: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

    p_we_acked_r7: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> sda_oe);

endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr)
);

// File: tb/i2c_regbank_target_test.sv
`timescale 1ns/1ps
module i2c_regbank_target_test;

    localparam int HALF = 10;
    localparam int QTR  = HALF / 2;

    typedef struct packed {
        logic [6:0]  dev;
        logic [15:0] ptr;
        logic [7:0]  dat;
        logic        ack;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{7'h28, 16'h0010, 8'hA5, 1'b1},
        '{7'h2F, 16'h0011, 8'h5A, 1'b1},
        '{7'h2B, 16'h0020, 8'h3C, 1'b1},
        '{7'h27, 16'h0030, 8'h11, 1'b0},
        '{7'h30, 16'h0031, 8'h22, 1'b0},
        '{7'h68, 16'h0032, 8'h33, 1'b0},
        '{7'h2C, 16'h1234, 8'hC3, 1'b1},
        '{7'h08, 16'h0040, 8'h44, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_drv = 1'b1;
    logic        sda_lo = 1'b0;
    logic        scl_line, sda_line;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic        reg_we, reg_re;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    always #4 clk = ~clk;

    assign scl_line = scl_drv;
    assign sda_line = ~(sda_lo | sda_oe);

    i2c_regbank_target uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Register-space model and strobe log
    logic [7:0]  mem [256];
    logic [15:0] wlog_a [64];
    logic [7:0]  wlog_d [64];
    int          wcount, rcount, drv_cnt;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            wcount    <= 0;
            rcount    <= 0;
            drv_cnt   <= 0;
            reg_rdata <= 8'h00;
        end else begin
            if (sda_oe) drv_cnt <= drv_cnt + 1;
            if (reg_we) begin
                mem[reg_addr[7:0]]  <= reg_wdata;
                wlog_a[wcount[5:0]] <= reg_addr;
                wlog_d[wcount[5:0]] <= reg_wdata;
                wcount              <= wcount + 1;
            end
            if (reg_re) begin
                reg_rdata <= mem[reg_addr[7:0]];
                rcount    <= rcount + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_lo = 1'b0; wait_n(HALF);
        scl_drv = 1'b1; wait_n(HALF);
        sda_lo = 1'b1; wait_n(HALF);
        scl_drv = 1'b0; wait_n(QTR);
    endtask

    task automatic bus_stop;
        sda_lo = 1'b1; wait_n(QTR);
        scl_drv = 1'b1; wait_n(HALF);
        sda_lo = 1'b0; wait_n(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_lo = ~b[i]; wait_n(QTR);
            scl_drv = 1'b1; wait_n(HALF);
            scl_drv = 1'b0; wait_n(QTR);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_lo = 1'b0; wait_n(QTR);
        scl_drv = 1'b1; wait_n(HALF / 2);
        ack = ~sda_line; wait_n(HALF - HALF / 2);
        scl_drv = 1'b0; wait_n(QTR);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_lo = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_n(QTR);
            scl_drv = 1'b1; wait_n(HALF / 2);
            b[i] = sda_line; wait_n(HALF - HALF / 2);
            scl_drv = 1'b0; wait_n(QTR);
        end
        sda_lo = give_ack; wait_n(QTR);
        scl_drv = 1'b1; wait_n(HALF);
        scl_drv = 1'b0; wait_n(QTR);
        sda_lo = 1'b0;
    endtask

    task automatic set_ptr(input logic [6:0] dev, input logic [15:0] p, output logic ok);
        logic a0, a1, a2;
        bus_start;
        send_byte({dev, 1'b0}, a0);
        send_byte(p[15:8], a1);
        send_byte(p[7:0], a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

    initial begin
        logic       a, ok;
        logic [7:0] rb;
        int         w0, r0, d0;

        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R9: reset state
        chk("R9 sda_oe after reset", 32'(sda_oe), 32'h0);
        chk("R9 strobes after reset", {30'h0, reg_we, reg_re}, 32'h0);
        chk("R9 pointer after reset", 32'(reg_addr), 32'h0);
        wait_n(HALF);

        // Table walk: write one byte, then read it back
        for (int i = 0; i < 8; i++) begin
            w0 = wcount;
            d0 = drv_cnt;
            bus_start;
            send_byte({VEC[i].dev, 1'b0}, a);
            chk($sformatf("R1 address ack vec %0d", i), 32'(a), 32'(VEC[i].ack));
            if (VEC[i].ack) begin
                logic a1, a2, a3;
                send_byte(VEC[i].ptr[15:8], a1);
                send_byte(VEC[i].ptr[7:0], a2);
                send_byte(VEC[i].dat, a3);
                bus_stop;
                chk($sformatf("R7 write acks vec %0d", i), {29'h0, a1, a2, a3}, 32'h7);
                chk($sformatf("R2 write address vec %0d", i), 32'(wlog_a[w0[5:0]]), 32'(VEC[i].ptr));
                chk($sformatf("R2 write data vec %0d", i), 32'(wlog_d[w0[5:0]]), 32'(VEC[i].dat));
                set_ptr(VEC[i].dev, VEC[i].ptr, ok);
                bus_start;
                send_byte({VEC[i].dev, 1'b1}, a);
                recv_byte(1'b0, rb);
                bus_stop;
                chk($sformatf("R4 read back vec %0d", i), 32'(rb), 32'(VEC[i].dat));
            end else begin
                logic a1, a2, a3;
                send_byte(VEC[i].ptr[15:8], a1);
                send_byte(VEC[i].ptr[7:0], a2);
                send_byte(VEC[i].dat, a3);
                bus_stop;
                chk($sformatf("R1 no write vec %0d", i), 32'(wcount - w0), 32'h0);
                chk($sformatf("R1 no drive vec %0d", i), 32'(drv_cnt - d0), 32'h0);
            end
            wait_n(HALF);
        end

        // R3: write stream across the pointer wrap
        w0 = wcount;
        set_ptr(7'h29, 16'hFFFE, ok);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop;
        chk("R3 stream write count", 32'(wcount - w0), 32'h3);
        chk("R3 stream addr 0", 32'(wlog_a[w0[5:0]]), 32'hFFFE);
        chk("R3 stream addr 1", 32'(wlog_a[6'(w0 + 1)]), 32'hFFFF);
        chk("R3 stream addr 2 wrap", 32'(wlog_a[6'(w0 + 2)]), 32'h0000);
        chk("R3 pointer after stream", 32'(reg_addr), 32'h0001);

        // R5: read stream ACK, ACK, NACK from 0xFFFE
        r0 = rcount;
        set_ptr(7'h29, 16'hFFFE, ok);
        bus_start;
        send_byte({7'h29, 1'b1}, a);
        recv_byte(1'b1, rb);
        chk("R5 read stream byte 0", 32'(rb), 32'h11);
        recv_byte(1'b1, rb);
        chk("R5 read stream byte 1", 32'(rb), 32'h22);
        recv_byte(1'b0, rb);
        chk("R5 read stream byte 2 wrap", 32'(rb), 32'h33);
        chk("R5 sda released after NACK", 32'(sda_oe), 32'h0);
        bus_stop;
        chk("R5 fetch count", 32'(rcount - r0), 32'h3);
        chk("R5 pointer after read", 32'(reg_addr), 32'h0001);

        // R6: read with no pointer bytes continues at stored pointer
        wait_n(HALF);
        bus_start;
        send_byte({7'h2E, 1'b1}, a);
        recv_byte(1'b0, rb);
        bus_stop;
        chk("R6 persistent pointer data", 32'(rb), 32'h5B);
        chk("R6 pointer advanced", 32'(reg_addr), 32'h0002);

        // R8: START in the middle of a data byte
        w0 = wcount;
        set_ptr(7'h28, 16'h0040, ok);
        send_bits(8'hF0, 4);
        bus_start;
        bus_stop;
        chk("R8 no write after abort", 32'(wcount - w0), 32'h0);
        chk("R8 pointer kept", 32'(reg_addr), 32'h0040);
        chk("R8 sda released", 32'(sda_oe), 32'h0);
        set_ptr(7'h28, 16'h0050, ok);
        send_byte(8'h77, a);
        bus_stop;
        chk("R8 recovery write count", 32'(wcount - w0), 32'h1);
        chk("R8 recovery write addr", 32'(wlog_a[w0[5:0]]), 32'h0050);
        chk("R8 recovery write data", 32'(wlog_d[w0[5:0]]), 32'h77);

        finish_run;
    end

endmodule